// File: doc/BRIEF.md
# Burst Sample Capture with Decimal Serial Dump

This block records one unbroken burst of converter samples at the full sample clock into an on-chip buffer. It then sends the whole buffer, much more slowly, through a serial transmitter as text. Each sample becomes one line: the sample's raw bits read as an unsigned decimal number, followed by a carriage return. The two sides run on separate clocks. The sample side takes a data word on every edge of `clk_s` and a start command. The system side owns the serial line and two status pins.

The sample input carries one word per `clk_s` edge and has no back-pressure, because a burst may never skip a sample. Inside the block, the decimal formatter hands bytes to the transmitter over a valid/ready stream. A byte that is offered stays offered, unchanged, until the transmitter takes it.

A start that arrives while a burst is being recorded, or while the buffer is being sent, has no effect. `SAMPLE_W` selects 12-bit or 14-bit samples. The burst length is `2**BURST_LOG2`. The full-size setting is `BURST_LOG2 = 15`, which gives 32768 samples. The default value is kept smaller so the storage stays modest.

Top module: `burst_capture_dump`

## Requirements
- R1: A start seen high on a `clk_s` edge while the block is armed stores the sample present on that same edge as record 0. It then stores the next `2**BURST_LOG2 - 1` samples from consecutive edges, with none skipped.
- R2: Each record is the unsigned decimal value of the stored bits, written as ASCII digits 0x30 to 0x39. Leading zeros are suppressed and at least one digit is always sent. The range is 0 to `2**SAMPLE_W - 1`.
- R3: Every record ends with exactly one byte 0x0D. Records leave in capture order, one for each stored sample.
- R4: The serial line idles high and sends 8N1 frames, LSB first. Each bit, the start bit included, lasts `CLK_HZ/BAUD` cycles of `clk`. The default `BAUD` is 115200.
- R5: `data_avail_o` is 0 after reset. It rises once a completed burst has crossed into the system domain through a two-flop synchroniser. It falls after the stop bit of the last carriage return has ended.
- R6: `ready_o` is 1 after reset. It falls in the same cycle as `data_avail_o` at the end of the first dump, and it stays 0 until the next reset.
- R7: A start during a capture or during a dump is ignored. The burst already being recorded stays unchanged, and no new burst or output follows from that start. Once a dump has ended, the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Sample clock |
| rst_s_n | input | 1 | Active-low reset, sample domain |
| start_i | input | 1 | Capture command, sampled on `clk_s` |
| sample_i | input | SAMPLE_W | Converter word, one per `clk_s` edge |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, system domain |
| uart_tx_o | output | 1 | Serial transmit line |
| data_avail_o | output | 1 | Captured data waiting or being sent |
| ready_o | output | 1 | On from reset until the first dump ends |

## Verification
The sample set covers zero, one-digit values, values just under and at powers of ten, a value with zeros inside it, a value with trailing zeros, and the full-scale code. A formatter that mishandled zero suppression would drop the inner or trailing zeros, or send nothing at all for zero. A second start is raised partway through a capture, and another is raised during the dump. A design that re-armed on either would shift the recorded window or send an extra burst. The width of the first start bit and the exact moments at which the two status pins change are also checked. These expose a transmitter with the wrong bit period and status logic that clears before the final stop bit has gone out.

// File: rtl/bdump_pkg.sv
package bdump_pkg;

  localparam logic [7:0] CR_BYTE    = 8'h0D;
  localparam logic [7:0] ASCII_ZERO = 8'h30;

  // number of decimal digits needed for the largest unsigned value of w bits
  function automatic int dec_digits(input int w);
    longint v;
    int n;
    v = (longint'(1) << w) - 1;
    n = 1;
    for (int i = 0; i < 20; i++) begin
      if (v >= 10) begin
        v = v / 10;
        n++;
      end
    end
    return n;
  endfunction

  function automatic int pow10(input int e);
    int r;
    r = 1;
    for (int i = 0; i < 10; i++) begin
      if (i < e) r = r * 10;
    end
    return r;
  endfunction

  typedef enum logic [1:0] {WR_ARMED, WR_FILL, WR_HELD} wr_state_e;
  typedef enum logic [1:0] {FM_IDLE, FM_SUB, FM_EMIT, FM_TERM} fm_state_e;
  typedef enum logic [2:0] {DC_IDLE, DC_ADDR, DC_LOAD, DC_WAIT, DC_DRAIN} dc_state_e;

endpackage

// File: rtl/capture_writer.sv
module capture_writer
  import bdump_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int BURST_LOG2 = 11
) (
  input  logic                  clk_s,
  input  logic                  rst_s_n,
  input  logic                  start_i,
  input  logic [SAMPLE_W-1:0]   sample_i,
  input  logic                  release_tgl_i,
  output logic                  we_o,
  output logic [BURST_LOG2-1:0] waddr_o,
  output logic [SAMPLE_W-1:0]   wdata_o,
  output logic                  done_tgl_o
);

  localparam logic [BURST_LOG2-1:0] LAST_ADDR = {BURST_LOG2{1'b1}};

  wr_state_e             state;
  logic [BURST_LOG2-1:0] waddr;
  logic                  rel_q1, rel_q2, rel_seen;

  always_comb begin
    we_o    = (state == WR_FILL) || ((state == WR_ARMED) && start_i);
    waddr_o = (state == WR_ARMED) ? '0 : waddr;
    wdata_o = sample_i;
  end

  always_ff @(posedge clk_s or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state      <= WR_ARMED;
      waddr      <= '0;
      done_tgl_o <= 1'b0;
      rel_q1     <= 1'b0;
      rel_q2     <= 1'b0;
      rel_seen   <= 1'b0;
    end else begin
      rel_q1 <= release_tgl_i;
      rel_q2 <= rel_q1;
      case (state)
        WR_ARMED: begin
          if (start_i) begin
            state <= WR_FILL;
            waddr <= BURST_LOG2'(1);
          end
        end
        WR_FILL: begin
          waddr <= waddr + 1'b1;
          if (waddr == LAST_ADDR) begin
            state      <= WR_HELD;
            done_tgl_o <= ~done_tgl_o;
          end
        end
        WR_HELD: begin
          if (rel_q2 != rel_seen) begin
            rel_seen <= rel_q2;
            state    <= WR_ARMED;
          end
        end
        default: state <= WR_ARMED;
      endcase
    end
  end

  AST_WRITE_CONTIG: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    (state == WR_FILL && $past(state == WR_FILL)) |-> (waddr == $past(waddr) + 1'b1)); // R1

  AST_START_WHILE_HELD: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    (state == WR_HELD && start_i && rel_q2 == rel_seen) |=> (state == WR_HELD)); // R7

endmodule

// File: rtl/dual_clk_buffer.sv
module dual_clk_buffer #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 11
) (
  input  logic              clk_w,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clk_r,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk_w) begin
    if (we_i) store[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_r) begin
    rdata_o <= store[raddr_i];
  end

endmodule

// File: rtl/dec_formatter.sv
module dec_formatter
  import bdump_pkg::*;
#(
  parameter int VALUE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [VALUE_W-1:0] value_i,
  output logic               done_o,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [7:0]         out_data_o
);

  localparam int NDIG = dec_digits(VALUE_W);
  localparam int IW   = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NDIG - 1);

  logic [VALUE_W-1:0] pow_tab [NDIG];

  for (genvar g = 0; g < NDIG; g++) begin : g_pow
    assign pow_tab[g] = VALUE_W'(pow10(NDIG - 1 - g));
  end

  fm_state_e          state;
  logic [VALUE_W-1:0] rem;
  logic [IW-1:0]      pidx;
  logic [3:0]         digit;
  logic               lead;

  always_comb begin
    out_valid_o = (state == FM_EMIT) || (state == FM_TERM);
    out_data_o  = (state == FM_TERM) ? CR_BYTE : (ASCII_ZERO + {4'd0, digit});
    done_o      = (state == FM_TERM) && out_ready_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FM_IDLE;
      rem   <= '0;
      pidx  <= '0;
      digit <= '0;
      lead  <= 1'b0;
    end else begin
      case (state)
        FM_IDLE: begin
          if (load_i) begin
            rem   <= value_i;
            pidx  <= '0;
            digit <= '0;
            lead  <= 1'b0;
            state <= FM_SUB;
          end
        end
        FM_SUB: begin
          if (rem >= pow_tab[pidx]) begin
            rem   <= rem - pow_tab[pidx];
            digit <= digit + 1'b1;
          end else if (digit != 0 || lead || pidx == LAST_IDX) begin
            state <= FM_EMIT;
          end else begin
            pidx <= pidx + 1'b1;
          end
        end
        FM_EMIT: begin
          if (out_ready_i) begin
            lead  <= 1'b1;
            digit <= '0;
            if (pidx == LAST_IDX) begin
              state <= FM_TERM;
            end else begin
              pidx  <= pidx + 1'b1;
              state <= FM_SUB;
            end
          end
        end
        FM_TERM: begin
          if (out_ready_i) state <= FM_IDLE;
        end
        default: state <= FM_IDLE;
      endcase
    end
  end

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R3

  AST_ASCII_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((out_data_o >= 8'h30 && out_data_o <= 8'h39) || out_data_o == CR_BYTE)); // R2

  AST_DIGIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FM_EMIT) |-> (digit <= 4'd9)); // R2

endmodule

// File: rtl/uart_byte_tx.sv
module uart_byte_tx #(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 115_200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic [7:0] in_data_i,
  output logic       tx_o,
  output logic       busy_o
);

  localparam int DIV = CLK_HZ / BAUD;
  localparam int CW  = $clog2(DIV + 1);

  logic [8:0]    shreg;
  logic [3:0]    bits_left;
  logic [CW-1:0] divcnt;

  assign in_ready_o = !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_o      <= 1'b1;
      busy_o    <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      divcnt    <= '0;
    end else if (!busy_o) begin
      if (in_valid_i) begin
        tx_o      <= 1'b0;
        shreg     <= {1'b1, in_data_i};
        bits_left <= 4'd9;
        divcnt    <= CW'(DIV - 1);
        busy_o    <= 1'b1;
      end
    end else if (divcnt != 0) begin
      divcnt <= divcnt - 1'b1;
    end else if (bits_left == 0) begin
      busy_o <= 1'b0;
    end else begin
      tx_o      <= shreg[0];
      shreg     <= {1'b1, shreg[8:1]};
      bits_left <= bits_left - 1'b1;
      divcnt    <= CW'(DIV - 1);
    end
  end

  AST_LINE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_o); // R4

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && divcnt != 0) |=> $stable(tx_o)); // R4

  AST_SOURCE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !in_ready_o) |=> (in_valid_i && $stable(in_data_i))); // R3

endmodule

// File: rtl/burst_capture_dump.sv
module burst_capture_dump
  import bdump_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int BURST_LOG2 = 11,
  parameter int CLK_HZ     = 100_000_000,
  parameter int BAUD       = 115_200
) (
  input  logic                clk_s,
  input  logic                rst_s_n,
  input  logic                start_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                clk,
  input  logic                rst_n,
  output logic                uart_tx_o,
  output logic                data_avail_o,
  output logic                ready_o
);

  localparam logic [BURST_LOG2-1:0] LAST_ADDR = {BURST_LOG2{1'b1}};

  logic                  we;
  logic [BURST_LOG2-1:0] waddr;
  logic [SAMPLE_W-1:0]   wdata;
  logic                  done_tgl;
  logic                  release_tgl;

  logic [BURST_LOG2-1:0] raddr;
  logic [SAMPLE_W-1:0]   rdata;

  logic                  fmt_load, fmt_done;
  logic                  byte_valid, byte_ready;
  logic [7:0]            byte_data;
  logic                  tx_busy;

  dc_state_e             state;
  logic                  dn_q1, dn_q2, dn_seen;

  capture_writer #(.SAMPLE_W(SAMPLE_W), .BURST_LOG2(BURST_LOG2)) u_writer (
    .clk_s        (clk_s),
    .rst_s_n      (rst_s_n),
    .start_i      (start_i),
    .sample_i     (sample_i),
    .release_tgl_i(release_tgl),
    .we_o         (we),
    .waddr_o      (waddr),
    .wdata_o      (wdata),
    .done_tgl_o   (done_tgl)
  );

  dual_clk_buffer #(.DATA_W(SAMPLE_W), .ADDR_W(BURST_LOG2)) u_buf (
    .clk_w  (clk_s),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .clk_r  (clk),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  dec_formatter #(.VALUE_W(SAMPLE_W)) u_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (fmt_load),
    .value_i    (rdata),
    .done_o     (fmt_done),
    .out_valid_o(byte_valid),
    .out_ready_i(byte_ready),
    .out_data_o (byte_data)
  );

  uart_byte_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid_i(byte_valid),
    .in_ready_o(byte_ready),
    .in_data_i (byte_data),
    .tx_o      (uart_tx_o),
    .busy_o    (tx_busy)
  );

  assign fmt_load = (state == DC_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= DC_IDLE;
      dn_q1        <= 1'b0;
      dn_q2        <= 1'b0;
      dn_seen      <= 1'b0;
      raddr        <= '0;
      data_avail_o <= 1'b0;
      ready_o      <= 1'b1;
      release_tgl  <= 1'b0;
    end else begin
      dn_q1 <= done_tgl;
      dn_q2 <= dn_q1;
      case (state)
        DC_IDLE: begin
          if (dn_q2 != dn_seen) begin
            dn_seen      <= dn_q2;
            data_avail_o <= 1'b1;
            raddr        <= '0;
            state        <= DC_ADDR;
          end
        end
        DC_ADDR: state <= DC_LOAD;
        DC_LOAD: state <= DC_WAIT;
        DC_WAIT: begin
          if (fmt_done) begin
            if (raddr == LAST_ADDR) begin
              state <= DC_DRAIN;
            end else begin
              raddr <= raddr + 1'b1;
              state <= DC_ADDR;
            end
          end
        end
        DC_DRAIN: begin
          if (!tx_busy) begin
            data_avail_o <= 1'b0;
            ready_o      <= 1'b0;
            release_tgl  <= ~release_tgl;
            state        <= DC_IDLE;
          end
        end
        default: state <= DC_IDLE;
      endcase
    end
  end

  AST_AVAIL_IN_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (state != DC_IDLE) |-> data_avail_o); // R5

  AST_AVAIL_LAST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_avail_o) |-> (uart_tx_o && !tx_busy)); // R5

  AST_READY_WITH_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> $fell(data_avail_o)); // R6

  AST_READY_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |=> !ready_o); // R6

endmodule

// File: tb/burst_capture_dump_tb.sv
`timescale 1ns/1ps
module burst_capture_dump_tb_top;

  localparam int SW    = 14;
  localparam int BL2   = 3;
  localparam int NREC  = 1 << BL2;
  localparam int CLKHZ = 1_152_000;
  localparam int BAUDR = 115_200;
  localparam int DIV   = CLKHZ / BAUDR;

  // two bursts of stimulus; expected text is derived from each value
  localparam int unsigned VEC [16] = '{
    16383, 0, 9, 10, 99, 100, 1005, 4095,
    10000, 1, 12345, 909, 16000, 42, 8191, 7 };

  logic clk = 1'b0, clk_s = 1'b0;
  logic rst_n = 1'b0, rst_s_n = 1'b0;
  logic start = 1'b0;
  logic [SW-1:0] sample = '0;
  logic tx, avail, rdy;

  int n_checks = 0, n_fail = 0;
  int low_run = 0, first_low = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always #1.5 clk_s = ~clk_s;

  burst_capture_dump #(.SAMPLE_W(SW), .BURST_LOG2(BL2), .CLK_HZ(CLKHZ), .BAUD(BAUDR)) dut_i (
    .clk_s(clk_s), .rst_s_n(rst_s_n), .start_i(start), .sample_i(sample),
    .clk(clk), .rst_n(rst_n), .uart_tx_o(tx), .data_avail_o(avail), .ready_o(rdy));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && tx == 1'b0) low_run = low_run + 1;
    else begin
      if (low_run != 0 && first_low == 0) first_low = low_run;
      low_run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic get_byte(output logic [7:0] b);
    logic stp;
    @(negedge clk);
    while (tx !== 1'b0) @(negedge clk);
    repeat (DIV / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = tx;
    end
    repeat (DIV) @(negedge clk);
    stp = tx;
    check(stp == 1'b1, "R4 stop bit", $sformatf("%0b", stp), "1");
  endtask

  task automatic get_record(output string s, output bit term_ok);
    logic [7:0] b;
    s = "";
    term_ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      get_byte(b);
      if (b == 8'h0D) begin
        term_ok = 1'b1;
        break;
      end
      s = {s, string'(b)};
    end
  endtask

  task automatic drive_burst(input int base, input bit extra_start);
    @(negedge clk_s);
    start  = 1'b1;
    sample = SW'(VEC[base]);
    for (int k = 1; k < NREC; k++) begin
      @(negedge clk_s);
      start  = extra_start && (k == 3);   // R7: restart mid-capture
      sample = SW'(VEC[base + k]);
    end
    @(negedge clk_s);
    start  = 1'b0;
    sample = SW'(14'h2AAA);
  endtask

  task automatic poke_during_dump();
    repeat (300) @(negedge clk_s);
    start  = 1'b1;
    sample = SW'(14'h1555);
    @(negedge clk_s);
    start  = 1'b0;
  endtask

  task automatic recv_burst(input int base);
    string got, exp;
    bit    term;
    for (int k = 0; k < NREC; k++) begin
      get_record(got, term);
      exp = $sformatf("%0d", VEC[base + k]);
      check(got == exp, $sformatf("R1 R2 record %0d", base + k), got, exp);
      check(term, "R3 CR terminator", $sformatf("%0b", term), "1");
      if (k == 0)
        check(avail == 1'b1, "R5 avail during dump", $sformatf("%0b", avail), "1");
    end
    repeat (DIV + 4) @(negedge clk);
    check(avail == 1'b0, "R5 avail after last stop", $sformatf("%0b", avail), "0");
    check(rdy == 1'b0, "R6 ready after dump", $sformatf("%0b", rdy), "0");
  endtask

  initial begin
    bit quiet;
    repeat (4) @(negedge clk);
    rst_n   = 1'b1;
    rst_s_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    check(tx == 1'b1, "R4 idle line", $sformatf("%0b", tx), "1");
    check(avail == 1'b0, "R5 avail at reset", $sformatf("%0b", avail), "0");
    check(rdy == 1'b1, "R6 ready at reset", $sformatf("%0b", rdy), "1");

    // burst A with a second start inside it and another during the dump
    fork
      begin
        drive_burst(0, 1'b1);
        poke_during_dump();
      end
      recv_burst(0);
    join
    check(first_low == DIV, "R4 bit period", $sformatf("%0d", first_low), $sformatf("%0d", DIV));

    // R7: the start raised during the dump must not produce a burst
    quiet = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tx !== 1'b1 || avail !== 1'b0) quiet = 1'b0;
    end
    check(quiet, "R7 start during dump ignored", $sformatf("%0b", quiet), "1");

    // burst B accepted after re-arm
    fork
      drive_burst(NREC, 1'b0);
      recv_burst(NREC);
    join
    check(rdy == 1'b0, "R6 ready stays low", $sformatf("%0b", rdy), "0");

    finish_run();
  end

endmodule